// File: doc/BRIEF.md
# Chained-Descriptor Frame Writer

This block is a write-only DMA engine that empties a pixel FIFO into frame buffers in memory. The buffers are found through a chain of two-word descriptors held in memory: word 0 gives the buffer's start address and word 1 gives the address of the descriptor for the next frame. The first descriptor's address comes from an input that software sets. When a descriptor's next pointer leads back to an earlier descriptor, the frames loop round a ring. Two descriptors that point at each other give ping-pong buffering. Longer chains give deeper rings.

Each frame runs in a fixed order. The engine reads both words of the descriptor in one 2-beat burst. It then writes the frame as a series of 32-bit bursts, each one launched when the FIFO holds enough words. At the end it pulses a done flag and moves to the next descriptor. The number of words per frame comes from a size input. No burst crosses a 1 KB address boundary.

The controller is a state machine with these states:
- IDLE: waits for `enable`, then goes to FETCH_REQ.
- FETCH_REQ: holds a 2-beat read until it is granted, then goes to FETCH_W0.
- FETCH_W0: waits for the first read word (the buffer address), then goes to FETCH_W1.
- FETCH_W1: waits for the second read word (the next pointer), then goes to WAIT_FILL.
- WAIT_FILL: goes to FRAME_END when no words remain, or to WR_REQ when the FIFO holds enough words.
- WR_REQ: holds the write request until it is granted, then goes to WR_BEATS.
- WR_BEATS: returns to WAIT_FILL after the last beat of the burst.
- FRAME_END: goes to FETCH_REQ when `enable` is high, otherwise to IDLE.

Top module: `fbdma_chain`

## Requirements
- R1: While reset is asserted, and afterwards while `enable` is low, `mem_req`, `mem_wvalid`, `fifo_rd` and `frame_done` are all 0.
- R2: Raising `enable` while the engine is idle starts a descriptor read at `first_desc`, with `mem_we`=0 and `mem_len`=2. The first returned word is the buffer address and the second is the next pointer. No write request is issued before both words have arrived.
- R3: Beat k of a frame (counting from 0) is written at buffer address + 4·k and carries the next word in FIFO order. Each frame has exactly `frame_words` beats. `mem_addr` shows the address of each beat while that beat is presented.
- R4: While at least BURST words remain in the frame, a write request is raised only when `fifo_level` ≥ BURST. When fewer words remain, the request is raised once `fifo_level` ≥ the number of words remaining. When a frame ends, every word fed to the FIFO for that frame has been consumed.
- R5: Each write burst is min(words remaining, BURST, words left before the next 1 KB boundary) beats long. No burst crosses a 1 KB boundary.
- R6: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_len` and `mem_we` unchanged until the cycle in which `mem_gnt` is high.
- R7: After the last beat of a frame, `frame_done` is high for exactly one cycle. The next descriptor is then read from the next pointer. A pointer back to an earlier descriptor loops the ring, including rings of three descriptors.
- R8: `enable` is sampled only while the engine is idle and at the end of each frame. If `enable` is low at the end of a frame, the engine returns to idle and issues no further requests.
- R9: `fifo_rd` is high exactly in the cycles where `mem_wvalid` and `mem_wready` are both high. `mem_wlast` marks the last beat of each burst. No pop is made while `fifo_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request. It is sampled only while idle and at each frame end. |
| first_desc | input | 32 | Address of the first descriptor |
| frame_words | input | FRAME_W | Number of 32-bit words per frame |
| fifo_level | input | LVL_W | Number of words currently held in the pixel FIFO |
| fifo_data | input | 32 | Word at the head of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pops the FIFO head |
| mem_req | output | 1 | Burst request, held until granted |
| mem_we | output | 1 | 1 = data write burst, 0 = descriptor read |
| mem_addr | output | 32 | Burst start address. During write beats, the address of the current beat. |
| mem_len | output | LEN_W | Burst length in beats |
| mem_gnt | input | 1 | Request accepted in this cycle |
| mem_rvalid | input | 1 | A read word is valid |
| mem_rdata | input | 32 | Read data |
| mem_wvalid | output | 1 | A write beat is valid |
| mem_wlast | output | 1 | This beat is the last one of the burst |
| mem_wdata | output | 32 | Write data |
| mem_wready | input | 1 | The write beat is accepted |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The burst-length decision has three limits that can bind in the same cycle: the count of words left in the frame and the distance to the next 1 KB boundary, alongside the BURST cap. The bench provokes this in two ways:
- A single-word frame placed on the last word before a boundary makes the remaining-count limit and the boundary limit both equal 1.
- Frames that start a few words below a boundary and end in a short tail make each limit bind in turn.

For every granted write, the bench works out the expected length on its own as min(remaining, BURST, distance to boundary) and compares it with `mem_len`. It also checks that the FIFO level met the threshold that R4 requires at the moment of the grant.

// File: rtl/fbdma_pkg.sv
package fbdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_W0,
        ST_FETCH_W1,
        ST_WAIT_FILL,
        ST_WR_REQ,
        ST_WR_BEATS,
        ST_FRAME_END
    } fbdma_state_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/fbdma_len.sv
// Burst sizing: picks the length of the next write burst and says when the
// FIFO holds enough words to launch it.
module fbdma_len #(
    parameter int unsigned BURST       = 8,
    parameter int unsigned FRAME_W     = 16,
    parameter int unsigned LVL_W       = 6,
    parameter int unsigned LEN_W       = 4,
    parameter int unsigned BOUND_BYTES = 1024,
    localparam int unsigned BOUND_WORDS = BOUND_BYTES / fbdma_pkg::WORD_BYTES,
    localparam int unsigned OFS_W       = $clog2(BOUND_WORDS)
) (
    input  logic [OFS_W-1:0]   word_ofs,
    input  logic [FRAME_W-1:0] rem,
    input  logic [LVL_W-1:0]   fifo_level,
    output logic [LEN_W-1:0]   len,
    output logic               fire
);

    logic [31:0] rem_x;
    logic [31:0] bnd_x;
    logic [31:0] need_x;
    logic [31:0] len_x;

    always_comb begin
        rem_x  = 32'(rem);
        bnd_x  = BOUND_WORDS - 32'(word_ofs);
        // Threshold: a full burst, or whatever is left of the frame.
        need_x = (rem_x < BURST) ? rem_x : BURST;
        // The 1 KB boundary may cut the burst shorter still.
        len_x  = (need_x < bnd_x) ? need_x : bnd_x;
        len    = LEN_W'(len_x);
        fire   = (rem_x != 32'd0) && (32'(fifo_level) >= need_x);
    end

endmodule

// File: rtl/fbdma_fsm.sv
// Controller: descriptor fetch, burst issue, beat counting and frame end.
module fbdma_fsm
    import fbdma_pkg::*;
#(
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned LEN_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [31:0]        first_desc,
    input  logic [FRAME_W-1:0] frame_words,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    input  logic               mem_wready,
    input  logic               fire,
    input  logic [LEN_W-1:0]   calc_len,
    output logic [31:0]        wr_addr,
    output logic [FRAME_W-1:0] rem,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [LEN_W-1:0]   mem_len,
    output logic               mem_wvalid,
    output logic               mem_wlast,
    output logic               fifo_rd,
    output logic               frame_done
);

    fbdma_state_e state, state_nx;

    logic [31:0]      desc_ptr;
    logic [31:0]      next_ptr;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] beat;
    logic [1:0]       words_in;
    logic             last_beat;

    assign last_beat = (beat == len_q - LEN_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (enable)     state_nx = ST_FETCH_REQ;
            ST_FETCH_REQ: if (mem_gnt)    state_nx = ST_FETCH_W0;
            ST_FETCH_W0:  if (mem_rvalid) state_nx = ST_FETCH_W1;
            ST_FETCH_W1:  if (mem_rvalid) state_nx = ST_WAIT_FILL;
            ST_WAIT_FILL: begin
                if (rem == '0) state_nx = ST_FRAME_END;
                else if (fire) state_nx = ST_WR_REQ;
            end
            ST_WR_REQ:    if (mem_gnt) state_nx = ST_WR_BEATS;
            ST_WR_BEATS:  if (mem_wready && last_beat) state_nx = ST_WAIT_FILL;
            ST_FRAME_END: state_nx = enable ? ST_FETCH_REQ : ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ptr <= '0;
            next_ptr <= '0;
            wr_addr  <= '0;
            rem      <= '0;
            len_q    <= '0;
            beat     <= '0;
            words_in <= '0;
        end else begin
            unique case (state)
                ST_IDLE:      if (enable) desc_ptr <= first_desc;
                ST_FETCH_REQ: if (mem_gnt) words_in <= 2'd0;
                ST_FETCH_W0: begin
                    if (mem_rvalid) begin
                        wr_addr  <= mem_rdata;
                        words_in <= 2'd1;
                    end
                end
                ST_FETCH_W1: begin
                    if (mem_rvalid) begin
                        next_ptr <= mem_rdata;
                        rem      <= frame_words;
                        words_in <= 2'd2;
                    end
                end
                ST_WAIT_FILL: if (rem != '0 && fire) len_q <= calc_len;
                ST_WR_REQ:    if (mem_gnt) beat <= '0;
                ST_WR_BEATS: begin
                    if (mem_wready) begin
                        wr_addr <= wr_addr + 32'(WORD_BYTES);
                        rem     <= rem - FRAME_W'(1);
                        beat    <= beat + LEN_W'(1);
                    end
                end
                ST_FRAME_END: desc_ptr <= next_ptr;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req    = (state == ST_FETCH_REQ) || (state == ST_WR_REQ);
        mem_we     = (state == ST_WR_REQ);
        mem_addr   = (state == ST_FETCH_REQ) ? desc_ptr : wr_addr;
        mem_len    = (state == ST_FETCH_REQ) ? LEN_W'(2) : len_q;
        mem_wvalid = (state == ST_WR_BEATS);
        mem_wlast  = (state == ST_WR_BEATS) && last_beat;
        fifo_rd    = (state == ST_WR_BEATS) && mem_wready;
        frame_done = (state == ST_FRAME_END);
    end

    // R2: no data write before both descriptor words are in
    a_r2_desc_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (words_in == 2'd2));

    // R6: a pending request holds steady until granted
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_we)));

    // R7: frame end is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9: last-beat marker only on a valid beat
    a_r9_wlast_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wlast |-> mem_wvalid);

endmodule

// File: rtl/fbdma_chain.sv
// Top level: descriptor-chained frame writer.
module fbdma_chain #(
    parameter int unsigned BURST       = 8,
    parameter int unsigned LVL_W       = 6,
    parameter int unsigned FRAME_W     = 16,
    parameter int unsigned BOUND_BYTES = 1024,
    localparam int unsigned LEN_W       = $clog2(BURST) + 1,
    localparam int unsigned BOUND_WORDS = BOUND_BYTES / fbdma_pkg::WORD_BYTES,
    localparam int unsigned OFS_W       = $clog2(BOUND_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [31:0]        first_desc,
    input  logic [FRAME_W-1:0] frame_words,
    input  logic [LVL_W-1:0]   fifo_level,
    input  logic [31:0]        fifo_data,
    output logic               fifo_rd,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [LEN_W-1:0]   mem_len,
    input  logic               mem_gnt,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               mem_wvalid,
    output logic               mem_wlast,
    output logic [31:0]        mem_wdata,
    input  logic               mem_wready,
    output logic               frame_done
);

    logic [31:0]      wr_addr;
    logic [FRAME_W-1:0] rem;
    logic [LEN_W-1:0] calc_len;
    logic             fire;

    fbdma_len #(
        .BURST      (BURST),
        .FRAME_W    (FRAME_W),
        .LVL_W      (LVL_W),
        .LEN_W      (LEN_W),
        .BOUND_BYTES(BOUND_BYTES)
    ) u_len (
        .word_ofs  (wr_addr[OFS_W+1:2]),
        .rem       (rem),
        .fifo_level(fifo_level),
        .len       (calc_len),
        .fire      (fire)
    );

    fbdma_fsm #(
        .FRAME_W(FRAME_W),
        .LEN_W  (LEN_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .first_desc (first_desc),
        .frame_words(frame_words),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_wready (mem_wready),
        .fire       (fire),
        .calc_len   (calc_len),
        .wr_addr    (wr_addr),
        .rem        (rem),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_len    (mem_len),
        .mem_wvalid (mem_wvalid),
        .mem_wlast  (mem_wlast),
        .fifo_rd    (fifo_rd),
        .frame_done (frame_done)
    );

    assign mem_wdata = fifo_data;

    // R5: a write burst stays inside one 1 KB window
    a_r5_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (32'(mem_addr[OFS_W+1:2]) + 32'(mem_len) <= BOUND_WORDS));

    // R4: the FIFO holds every word of a requested burst
    a_r4_level_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (32'(fifo_level) >= 32'(mem_len)));

    // R9: never pop an empty FIFO
    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (fifo_level != '0));

endmodule

// File: tb/fbdma_chain_tb.sv
module fbdma_chain_tb;

    localparam int unsigned BURST   = 8;
    localparam int unsigned LVL_W   = 6;
    localparam int unsigned FRAME_W = 16;
    localparam int unsigned LEN_W   = 4;
    localparam logic [31:0] DBASE   = 32'h100;

    typedef struct packed {
        logic [15:0] words;
        logic [31:0] d0;
        logic [31:0] d1;
        logic [31:0] d2;
        logic [3:0]  wp;
        logic [3:0]  gp;
        logic [3:0]  frames;
        logic [7:0]  hold;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{16'd16, 32'h2000, 32'h3000, 32'h0,    4'hF,    4'hF,    4'd2, 8'd0}, // exact bursts
        '{16'd13, 32'h2000, 32'h3000, 32'h0,    4'hF,    4'hF,    4'd3, 8'd0}, // tail, ring wrap
        '{16'd20, 32'h23F0, 32'h5000, 32'h0,    4'b1011, 4'b0101, 4'd2, 8'd0}, // boundary split
        '{16'd1,  32'h7000, 32'h73FC, 32'h0,    4'b0110, 4'hF,    4'd2, 8'd0}, // single word at edge
        '{16'd30, 32'h13E8, 32'h9FF8, 32'h0,    4'b1100, 4'b1110, 4'd3, 8'd0}, // both split
        '{16'd9,  32'h1000, 32'h2000, 32'h3000, 4'hF,    4'b1010, 4'd4, 8'd0}, // 3-ring
        '{16'd16, 32'h4000, 32'h4400, 32'h0,    4'hF,    4'hF,    4'd2, 8'd7}  // threshold hold
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [31:0] first_desc = DBASE;
    logic [FRAME_W-1:0] frame_words = '0;
    logic [LVL_W-1:0] fifo_level;
    logic [31:0] fifo_data;
    logic fifo_rd;
    logic mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [LEN_W-1:0] mem_len;
    logic mem_gnt;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic mem_wvalid, mem_wlast;
    logic [31:0] mem_wdata;
    logic mem_wready;
    logic frame_done;

    always #4 clk = ~clk;

    fbdma_chain u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .first_desc(first_desc),
        .frame_words(frame_words), .fifo_level(fifo_level), .fifo_data(fifo_data),
        .fifo_rd(fifo_rd), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_wvalid(mem_wvalid), .mem_wlast(mem_wlast),
        .mem_wdata(mem_wdata), .mem_wready(mem_wready), .frame_done(frame_done)
    );

    // ---------------- memory slave and FIFO models ----------------
    logic [31:0] dmem [0:11];
    logic [3:0]  wpat = 4'hF;
    logic [3:0]  gpat = 4'hF;
    logic [31:0] cyc = '0;
    int          rd_left = 0;
    logic [31:0] rd_addr = '0;
    int          lvl = 0;
    logic [31:0] fdat = 32'h1000_0000;
    int          pushed = 0;
    int          feed_limit = 0;

    function automatic logic [31:0] dword(input logic [31:0] a);
        logic [31:0] idx;
        idx = (a - DBASE) >> 2;
        if (idx < 32'd12) return dmem[idx[3:0]];
        return 32'hDEAD_BEEF;
    endfunction

    assign mem_wready = wpat[cyc[1:0]];
    assign mem_gnt    = gpat[cyc[1:0]];
    assign fifo_level = LVL_W'(lvl);
    assign fifo_data  = fdat;

    always @(posedge clk) begin
        bit push;
        cyc <= cyc + 32'd1;
        if (rd_left != 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= dword(rd_addr);
            rd_addr    <= rd_addr + 32'd4;
            rd_left    <= rd_left - 1;
        end else begin
            mem_rvalid <= 1'b0;
        end
        if (mem_req && mem_gnt && !mem_we) begin
            rd_left <= 2;
            rd_addr <= mem_addr;
        end
        push = (pushed < feed_limit) && (lvl < 60);
        lvl <= lvl + (push ? 1 : 0) - (fifo_rd ? 1 : 0);
        if (push) pushed <= pushed + 1;
        if (fifo_rd) fdat <= fdat + 32'd1;
    end

    // ---------------- monitor (samples at the falling edge) ----------------
    int          run_id = 0, seen_id = 0;
    logic [31:0] exp_desc = '0, exp_next = '0, exp_addr = '0;
    logic [31:0] exp_data = 32'h1000_0000;
    int          exp_rem = 0, cur_len = 0, beat_in = 0, rv_cnt = 0;
    int          done_cnt = 0, beat_cnt = 0, wreq_cnt = 0;
    int          m_chk = 0, m_err = 0;
    bit          hold_v = 1'b0;
    logic [31:0] hold_a = '0;
    logic [LEN_W-1:0] hold_l = '0;

    task automatic mchk(input string r, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        m_chk++;
        if (!ok) begin
            m_err++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            int need, bnd, elen;
            if (run_id != seen_id) begin
                seen_id  = run_id;
                exp_desc = first_desc;
            end
            if (hold_v)
                mchk("R6 held request", mem_req && mem_addr == hold_a && mem_len == hold_l,
                     mem_addr, hold_a);
            hold_v = mem_req && !mem_gnt;
            hold_a = mem_addr;
            hold_l = mem_len;
            if (mem_rvalid) rv_cnt++;
            if (mem_req && mem_gnt && !mem_we) begin
                mchk("R2 fetch addr", mem_addr == exp_desc, mem_addr, exp_desc);
                mchk("R2 fetch len", mem_len == LEN_W'(2), 32'(mem_len), 32'd2);
                exp_addr = dword(exp_desc);
                exp_next = dword(exp_desc + 32'd4);
                exp_rem  = int'(frame_words);
                rv_cnt   = 0;
            end
            if (mem_req && mem_gnt && mem_we) begin
                wreq_cnt++;
                need = (exp_rem < int'(BURST)) ? exp_rem : int'(BURST);
                bnd  = 256 - int'(exp_addr[9:2]);
                elen = (need < bnd) ? need : bnd;
                mchk("R2 both words first", rv_cnt == 2, 32'(rv_cnt), 32'd2);
                mchk("R3 burst addr", mem_addr == exp_addr, mem_addr, exp_addr);
                mchk("R5 burst len", int'(mem_len) == elen, 32'(mem_len), 32'(elen));
                mchk("R4 threshold", int'(fifo_level) >= need, 32'(fifo_level), 32'(need));
                cur_len = int'(mem_len);
                beat_in = 0;
            end
            if (mem_wvalid && mem_wready) begin
                mchk("R3 beat data", mem_wdata == exp_data, mem_wdata, exp_data);
                mchk("R3 beat addr", mem_addr == exp_addr, mem_addr, exp_addr);
                mchk("R9 pop", fifo_rd == 1'b1, 32'(fifo_rd), 32'd1);
                mchk("R9 wlast", mem_wlast == (beat_in == cur_len - 1), 32'(mem_wlast),
                     32'(beat_in == cur_len - 1));
                exp_addr = exp_addr + 32'd4;
                exp_data = exp_data + 32'd1;
                exp_rem--;
                beat_in++;
                beat_cnt++;
            end else if (mem_wvalid) begin
                mchk("R9 no pop on stall", fifo_rd == 1'b0, 32'(fifo_rd), 32'd0);
            end
            if (frame_done) begin
                mchk("R7 frame complete", exp_rem == 0, 32'(exp_rem), 32'd0);
                done_cnt++;
                exp_desc = exp_next;
            end
        end
    end

    // ---------------- directed sequence ----------------
    int t_chk = 0, t_err = 0;

    task automatic tchk(input string r, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        t_chk++;
        if (!ok) begin
            t_err++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int d0, b0, w0, base;
        bit saw;
        dmem[0] = v.d0;  dmem[1] = DBASE + 32'h10;
        dmem[4] = v.d1;  dmem[5] = (v.d2 != 0) ? DBASE + 32'h20 : DBASE;
        dmem[8] = v.d2;  dmem[9] = DBASE;
        frame_words = FRAME_W'(v.words);
        wpat = v.wp;
        gpat = v.gp;
        d0 = done_cnt; b0 = beat_cnt; w0 = wreq_cnt;
        base = pushed;
        feed_limit = (v.hold != 0) ? base + int'(v.hold) : base + int'(v.words) * int'(v.frames);
        run_id++;
        enable = 1'b1;
        if (v.hold != 0) begin
            repeat (60) @(negedge clk);
            tchk("R4 below threshold no request", wreq_cnt == w0, 32'(wreq_cnt - w0), 32'd0);
            tchk("R4 level held", int'(fifo_level) == int'(v.hold), 32'(fifo_level), 32'(v.hold));
            feed_limit = base + int'(v.words) * int'(v.frames);
        end
        while (done_cnt < d0 + int'(v.frames) - 1) @(negedge clk);
        enable = 1'b0;
        while (done_cnt < d0 + int'(v.frames)) @(negedge clk);
        saw = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (mem_req) saw = 1'b1;
        end
        tchk("R8 idle after stop", saw == 1'b0, 32'(saw), 32'd0);
        tchk("R3 beats per run", beat_cnt - b0 == int'(v.words) * int'(v.frames),
             32'(beat_cnt - b0), 32'(int'(v.words) * int'(v.frames)));
        tchk("R7 frames per run", done_cnt - d0 == int'(v.frames), 32'(done_cnt - d0), 32'(v.frames));
        tchk("R4 drained", fifo_level == '0, 32'(fifo_level), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 12; i++) dmem[i] = '0;
        repeat (3) @(negedge clk);
        tchk("R1 reset outputs", !mem_req && !mem_wvalid && !fifo_rd && !frame_done,
             {28'd0, mem_req, mem_wvalid, fifo_rd, frame_done}, 32'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        tchk("R1 idle while disabled", !mem_req && !mem_wvalid && !fifo_rd && !frame_done,
             {28'd0, mem_req, mem_wvalid, fifo_rd, frame_done}, 32'd0);
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);
        $display("Result: errors=%0d of %0d checks", m_err + t_err, m_chk + t_chk);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 32'd100000) begin
            $display("FAIL watchdog R7: actual=hung expected=all frames done");
            $display("Result: errors=%0d of %0d checks", m_err + t_err + 1, m_chk + t_chk + 1);
            $finish;
        end
    end

endmodule